// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer for a 72-bit Module

This block is a synchronous controller for an asynchronous DRAM module that is 72 bits wide, carrying 64 data bits and 8 check bits, with a multiplexed 11-bit address. A host issues single-word read or write requests over a valid/ready port. Each request carries a row, a column, write data, check bits and eight byte enables. The controller turns each request into strobe sequences on the row strobe, eight column strobes, write enable, output enable and the shared address pins. All strobes are active low.

After a row has been opened it stays open. A later request to the same row is served by pulsing only the column strobes. A request to a different row first closes the open row and waits out the full precharge time. On its own schedule the controller issues refresh cycles in which the column strobes fall before the row strobe. After reset it runs a fixed number of refresh cycles before it accepts any request.

Read capture follows one of two timings, chosen by a mode input. In fast-page timing the read word is taken while the column strobes are still low. In extended-data-out timing it is taken after the column strobes have risen again, so the strobe precharge overlaps the data window.

Top module: `pdram_ctrl`

## Requirements
- R1: Out of reset, `dram_ras_n` is high, all of `dram_cas_n` is high and `req_ready` is low. `req_ready` stays low until INIT_REFS (default 8) refresh cycles have completed.
- R2: Row and column addresses are multiplexed on `dram_addr`. The row value is on the pins when `dram_ras_n` falls. The column value is on the pins when the column strobes fall, which is no sooner than P_RCD cycles after `dram_ras_n` fell.
- R3: Writes are early writes. `dram_we_n` goes low and `dram_dq_out` is driven with `dram_dq_oe` high at least one cycle before any column strobe falls. `dram_oe_n` stays high while `dram_we_n` is low.
- R4: Lane i of the 72-bit bus is `dram_dq_out[9i+8:9i]`, equal to {check bit i, data byte i}. On a write only the column strobes whose `req_be` bit is set fall. Lanes that are not enabled keep their old contents.
- R5: A read pulls all eight column strobes low together, with `dram_we_n` high and `dram_oe_n` low.
- R6: With `edo_en` low, read data is sampled on the last cycle in which the column strobes are low. With `edo_en` high, it is sampled on the first cycle after they have risen, with the row strobe and output enable still low.
- R7: A request to the currently open row does not toggle `dram_ras_n`. It is served with column strobes only.
- R8: Every low-going edge of `dram_ras_n` follows at least P_RP consecutive cycles with `dram_ras_n` high. This includes opening a different row while a page is open.
- R9: About every REF_CYCLES cycles a refresh is issued. All column strobes fall while `dram_ras_n` is high. Then `dram_ras_n` falls with `dram_we_n` high. An open page is closed and precharged before the refresh starts.
- R10: Each accepted read produces exactly one `rsp_valid` pulse. `rsp_rdata` and `rsp_rcb` hold the addressed word, split into lanes as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edo_en | input | 1 | 1 selects extended-data-out read capture, 0 selects fast-page capture |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | 11 | Row address |
| req_col | input | 11 | Column address |
| req_wdata | input | 64 | Write data |
| req_wcb | input | 8 | Write check bits |
| req_be | input | 8 | Byte-lane enables for writes |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_rcb | output | 8 | Read check bits |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 8 | Column strobes, one per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 72 | Write data toward the module |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 72 | Read data from the module |

## Verification
The bench's memory model puts the word on the bus only inside the valid window for the selected mode. In fast-page mode the word is present while the column strobes are low. In extended-data-out mode it is present only after they have risen. A design that samples at the wrong moment therefore returns a filler pattern instead of the word. The model also records row openings, refreshes, precharge widths and any write-enable edge that falls while a column strobe is low. As a result:
- A page hit that reopens the row shows up as an extra row opening.
- A short precharge shows up as a precharge-width violation.
- Late writes are caught by the write-enable edge check.
- Refreshes issued with the wrong strobe order are caught because the refresh count and the count of column strobes falling while the row strobe is high disagree.

A partial byte-enable write followed by a read-back shows any lane that was strobed when it should not have been, or a lane mapping that is off.

// File: rtl/pdram_pkg.sv
package pdram_pkg;

    localparam int ADDR_W = 11;
    localparam int LANES  = 8;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int BUS_W  = LANES * LANE_W;

    typedef enum logic [3:0] {
        S_PRE, S_IDLE, S_ACT, S_COL, S_CASLO, S_CASHI, S_OPEN, S_CBR_C, S_CBR_R
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  cb;
        logic [LANES-1:0]  be;
    } host_req_t;

endpackage

// File: rtl/pdram_refresh_timer.sv
module pdram_refresh_timer #(
    parameter int INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(INTERVAL - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/pdram_lane_map.sv
module pdram_lane_map
    import pdram_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wcb,
    output logic [BUS_W-1:0]  bus_out,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rcb
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bus_out[i*LANE_W +: LANE_W] = {wcb[i], wdata[i*BYTE_W +: BYTE_W]};
        assign rdata[i*BYTE_W +: BYTE_W]   = bus_in[i*LANE_W +: BYTE_W];
        assign rcb[i]                      = bus_in[i*LANE_W + BYTE_W];
    end
endmodule

// File: rtl/pdram_seq.sv
module pdram_seq
    import pdram_pkg::*;
#(
    parameter int P_RCD     = 4,
    parameter int P_CAS     = 3,
    parameter int P_CP      = 2,
    parameter int P_RP      = 8,
    parameter int P_CSR     = 2,
    parameter int P_CBR_RAS = 13,
    parameter int INIT_REFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edo_en,
    input  logic              ref_tick,
    input  logic              req_valid,
    input  host_req_t         req_in,
    output logic              req_ready,
    output logic              ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic              drive_en,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wcb,
    output logic              cap_en
);
    localparam int CNT_W  = $clog2(P_RCD + P_CAS + P_CP + P_RP + P_CSR + P_CBR_RAS + 1);
    localparam int INIT_W = $clog2(INIT_REFS + 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    host_req_t         cur;
    logic              have_req;
    logic              ref_pend;
    logic [ADDR_W-1:0] open_row;
    logic [INIT_W-1:0] init_left;
    logic              init_done;
    logic              accept;
    logic              in_col;

    assign init_done = (init_left == '0);
    assign req_ready = (state == S_IDLE || state == S_OPEN) && !have_req && !ref_pend && init_done;
    assign accept    = req_valid && req_ready;
    assign in_col    = (state == S_COL) || (state == S_CASLO) || (state == S_CASHI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_PRE;
            cnt       <= CNT_W'(P_RP - 1);
            cur       <= '0;
            have_req  <= 1'b0;
            ref_pend  <= 1'b0;
            open_row  <= '0;
            init_left <= INIT_W'(INIT_REFS);
        end else begin
            if (ref_tick) ref_pend <= 1'b1;
            if (accept) begin
                cur      <= req_in;
                have_req <= 1'b1;
            end
            case (state)
                S_PRE: if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
                S_IDLE: begin
                    if (have_req) begin
                        state    <= S_ACT;
                        cnt      <= CNT_W'(P_RCD - 1);
                        open_row <= cur.row;
                    end else if (ref_pend || !init_done) begin
                        state    <= S_CBR_C;
                        cnt      <= CNT_W'(P_CSR - 1);
                        ref_pend <= ref_tick;
                    end
                end
                S_ACT: if (cnt == '0) state <= S_COL; else cnt <= cnt - 1'b1;
                S_COL: begin
                    state <= S_CASLO;
                    cnt   <= CNT_W'(P_CAS - 1);
                end
                S_CASLO: begin
                    if (cnt == '0) begin
                        state <= S_CASHI;
                        cnt   <= CNT_W'(P_CP - 1);
                    end else cnt <= cnt - 1'b1;
                end
                S_CASHI: begin
                    if (cnt == '0) begin
                        state    <= S_OPEN;
                        have_req <= 1'b0;
                    end else cnt <= cnt - 1'b1;
                end
                S_OPEN: begin
                    if (have_req && cur.row == open_row) begin
                        state <= S_COL;
                    end else if (have_req || ref_pend) begin
                        state <= S_PRE;
                        cnt   <= CNT_W'(P_RP - 1);
                    end
                end
                S_CBR_C: begin
                    if (cnt == '0) begin
                        state <= S_CBR_R;
                        cnt   <= CNT_W'(P_CBR_RAS - 1);
                    end else cnt <= cnt - 1'b1;
                end
                S_CBR_R: begin
                    if (cnt == '0) begin
                        state <= S_PRE;
                        cnt   <= CNT_W'(P_RP - 1);
                        if (!init_done) init_left <= init_left - 1'b1;
                    end else cnt <= cnt - 1'b1;
                end
                default: state <= S_PRE;
            endcase
        end
    end

    always_comb begin
        ras_n    = !(in_col || state == S_ACT || state == S_OPEN || state == S_CBR_R);
        cas_n    = '1;
        if (state == S_CASLO) cas_n = cur.wr ? ~cur.be : '0;
        if (state == S_CBR_C || state == S_CBR_R) cas_n = '0;
        we_n     = !(cur.wr && in_col);
        drive_en = cur.wr && in_col;
        oe_n     = !(!cur.wr && (state == S_COL || state == S_CASLO || (state == S_CASHI && edo_en)));
        if (state == S_IDLE || state == S_ACT) addr = cur.row;
        else if (in_col)                       addr = cur.col;
        else                                   addr = '0;
        cap_en   = !cur.wr && (edo_en ? (state == S_CASHI && cnt == CNT_W'(P_CP - 1))
                                      : (state == S_CASLO && cnt == '0));
    end

    assign wdata = cur.data;
    assign wcb   = cur.cb;
endmodule

// File: rtl/pdram_ctrl.sv
module pdram_ctrl
    import pdram_pkg::*;
#(
    parameter int P_RCD      = 4,
    parameter int P_CAS      = 3,
    parameter int P_CP       = 2,
    parameter int P_RP       = 8,
    parameter int P_CSR      = 2,
    parameter int P_CBR_RAS  = 13,
    parameter int INIT_REFS  = 8,
    parameter int REF_CYCLES = 3900
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        edo_en,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [10:0] req_row,
    input  logic [10:0] req_col,
    input  logic [63:0] req_wdata,
    input  logic [7:0]  req_wcb,
    input  logic [7:0]  req_be,
    output logic        rsp_valid,
    output logic [63:0] rsp_rdata,
    output logic [7:0]  rsp_rcb,
    output logic        dram_ras_n,
    output logic [7:0]  dram_cas_n,
    output logic        dram_we_n,
    output logic        dram_oe_n,
    output logic [10:0] dram_addr,
    output logic [71:0] dram_dq_out,
    output logic        dram_dq_oe,
    input  logic [71:0] dram_dq_in
);
    logic              ref_tick;
    logic              cap_en;
    host_req_t         req_in;
    logic [DATA_W-1:0] wdata, rd_word;
    logic [LANES-1:0]  wcb, rd_cb;

    assign req_in = '{wr: req_write, row: req_row, col: req_col,
                      data: req_wdata, cb: req_wcb, be: req_be};

    pdram_refresh_timer #(.INTERVAL(REF_CYCLES)) i_timer (
        .clk(clk), .rst(rst), .tick(ref_tick)
    );

    pdram_seq #(
        .P_RCD(P_RCD), .P_CAS(P_CAS), .P_CP(P_CP), .P_RP(P_RP),
        .P_CSR(P_CSR), .P_CBR_RAS(P_CBR_RAS), .INIT_REFS(INIT_REFS)
    ) i_seq (
        .clk(clk), .rst(rst), .edo_en(edo_en), .ref_tick(ref_tick),
        .req_valid(req_valid), .req_in(req_in), .req_ready(req_ready),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
        .addr(dram_addr), .drive_en(dram_dq_oe), .wdata(wdata), .wcb(wcb),
        .cap_en(cap_en)
    );

    pdram_lane_map i_lanes (
        .wdata(wdata), .wcb(wcb), .bus_out(dram_dq_out),
        .bus_in(dram_dq_in), .rdata(rd_word), .rcb(rd_cb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_rcb   <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_rdata <= rd_word;
                rsp_rcb   <= rd_cb;
            end
        end
    end
endmodule

// File: rtl/pdram_ctrl_chk.sv
module pdram_ctrl_chk #(
    parameter int P_RCD     = 4,
    parameter int P_RP      = 8,
    parameter int INIT_REFS = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       dram_ras_n,
    input logic [7:0] dram_cas_n,
    input logic       dram_we_n,
    input logic       dram_oe_n,
    input logic       dram_dq_oe
);
    logic [7:0] hi_cnt, lo_cnt, ref_seen;
    logic       any_cas;

    assign any_cas = (dram_cas_n != 8'hFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            ref_seen <= '0;
        end else begin
            hi_cnt <= dram_ras_n ? ((hi_cnt != 8'hFF) ? hi_cnt + 1'b1 : hi_cnt) : '0;
            lo_cnt <= !dram_ras_n ? ((lo_cnt != 8'hFF) ? lo_cnt + 1'b1 : lo_cnt) : '0;
            if (hi_cnt != 0 && !dram_ras_n && dram_cas_n == 8'h00 && ref_seen != 8'hFF)
                ref_seen <= ref_seen + 1'b1;
        end
    end

    AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (int'(ref_seen) >= INIT_REFS));  // R1
    AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (rst)
        ($rose(any_cas) && !dram_ras_n) |-> (int'(lo_cnt) >= P_RCD));  // R2
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($rose(any_cas) && !dram_ras_n && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe)));  // R3
    AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> dram_oe_n);  // R3
    AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && dram_we_n && any_cas) |-> (dram_cas_n == 8'h00));  // R5
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (int'(hi_cnt) >= P_RP));  // R8
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && dram_cas_n == 8'h00) |-> ($past(dram_cas_n) == 8'h00 && dram_we_n));  // R9
endmodule

bind pdram_ctrl pdram_ctrl_chk #(.P_RCD(P_RCD), .P_RP(P_RP), .INIT_REFS(INIT_REFS)) i_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/test_pdram_ctrl.sv
`timescale 1ns/1ps
module test_pdram_ctrl;
    localparam int P_RP = 8;
    localparam logic [71:0] GARB = 72'hE5_A5A5_5A5A_A5A5_5A5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic edo_en = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_row = '0, req_col = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_wcb = '0, req_be = '0;
    logic req_ready, rsp_valid, dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [63:0] rsp_rdata;
    logic [7:0]  rsp_rcb, dram_cas_n;
    logic [10:0] dram_addr;
    logic [71:0] dram_dq_out;
    logic [71:0] dram_dq_in = GARB;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    pdram_ctrl i_pdram_ctrl (
        .clk(clk), .rst(rst), .edo_en(edo_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .req_wcb(req_wcb), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_rcb(rsp_rcb), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // Behavioural DRAM module model, evaluated away from the active edge
    logic [71:0] mem [256];
    logic        prev_ras = 1'b1, prev_we = 1'b1, col_ok = 1'b0;
    logic [7:0]  prev_cas = 8'hFF;
    logic [10:0] row_l = '0, col_l = '0;
    int hi_w = 0, act_cnt = 0, ref_cnt = 0, cbr_starts = 0, pre_viol = 0;
    int late_wr = 0, bad_drv = 0, rsp_cnt = 0;

    initial for (int k = 0; k < 256; k++) mem[k] = '0;

    always @(negedge clk) begin
        logic [7:0] fell;
        logic       rd_ok;
        if (rsp_valid) rsp_cnt++;
        if (!rst) begin
            if (prev_ras && !dram_ras_n) begin
                if (hi_w < P_RP) pre_viol++;
                if (dram_cas_n == 8'h00) ref_cnt++;
                else begin act_cnt++; row_l = dram_addr; end
            end
            hi_w = dram_ras_n ? hi_w + 1 : 0;
            fell = prev_cas & ~dram_cas_n;
            if (fell != 8'h00) begin
                if (dram_ras_n) cbr_starts++;
                else begin
                    col_l  = dram_addr;
                    col_ok = 1'b1;
                    if (!dram_we_n) begin
                        if (!dram_dq_oe) bad_drv++;
                        for (int i = 0; i < 8; i++)
                            if (fell[i]) mem[{row_l[3:0], col_l[3:0]}][i*9 +: 9] = dram_dq_out[i*9 +: 9];
                    end
                end
            end
            if (prev_we && !dram_we_n && dram_cas_n != 8'hFF) late_wr++;
            if (dram_ras_n) col_ok = 1'b0;
            rd_ok = !dram_ras_n && dram_we_n && !dram_oe_n && col_ok;
            if (edo_en) dram_dq_in <= (rd_ok && dram_cas_n == 8'hFF) ? mem[{row_l[3:0], col_l[3:0]}] : GARB;
            else        dram_dq_in <= (rd_ok && dram_cas_n == 8'h00) ? mem[{row_l[3:0], col_l[3:0]}] : GARB;
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
        prev_we  = dram_we_n;
    end

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_req(input bit wr, input logic [10:0] row, input logic [10:0] col,
                            input logic [63:0] d, input logic [7:0] cb, input logic [7:0] be);
        @(negedge clk);
        req_write = wr; req_row = row; req_col = col;
        req_wdata = d; req_wcb = cb; req_be = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_read(input logic [10:0] row, input logic [10:0] col,
                             output logic [63:0] d, output logic [7:0] cb);
        host_req(1'b0, row, col, '0, '0, '0);
        while (!rsp_valid) @(negedge clk);
        d = rsp_rdata; cb = rsp_rcb;
        @(negedge clk);
    endtask

    task automatic wait_open();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(dram_ras_n == 1'b1 && dram_cas_n == 8'hFF, "R1 strobes idle in reset", {63'd0, dram_ras_n, dram_cas_n}, {63'd1, 8'hFF});
        check(req_ready == 1'b0, "R1 not ready in reset", {71'd0, req_ready}, 72'd0);
        rst = 1'b0;
        while (!req_ready) @(negedge clk);
        check(ref_cnt == 8, "R1 init refreshes before ready", 72'(ref_cnt), 72'd8);
        check(cbr_starts == ref_cnt, "R9 CAS precedes RAS on refresh", 72'(cbr_starts), 72'(ref_cnt));
    endtask

    task automatic t_fpm_rw();
        logic [63:0] d; logic [7:0] cb;
        edo_en = 1'b0;
        host_req(1'b1, 11'd1, 11'd2, 64'h1111_2222_3333_4444, 8'hA1, 8'hFF);
        host_req(1'b1, 11'd1, 11'd3, 64'h5555_6666_7777_8888, 8'h3C, 8'hFF);
        wait_open();
        host_read(11'd1, 11'd2, d, cb);
        check({cb, d} == {8'hA1, 64'h1111_2222_3333_4444}, "R2 R6 fast-page read col 2", {cb, d}, {8'hA1, 64'h1111_2222_3333_4444});
        host_read(11'd1, 11'd3, d, cb);
        check({cb, d} == {8'h3C, 64'h5555_6666_7777_8888}, "R5 R6 fast-page read col 3", {cb, d}, {8'h3C, 64'h5555_6666_7777_8888});
        check(late_wr == 0 && bad_drv == 0, "R3 early write with data driven", 72'(late_wr + bad_drv), 72'd0);
    endtask

    task automatic t_page_hit();
        int a0; logic [63:0] d; logic [7:0] cb;
        a0 = act_cnt;
        host_req(1'b1, 11'd1, 11'd4, 64'hCAFE_F00D_0BAD_BEEF, 8'h5A, 8'hFF);
        wait_open();
        host_read(11'd1, 11'd4, d, cb);
        check({cb, d} == {8'h5A, 64'hCAFE_F00D_0BAD_BEEF}, "R7 page hit data", {cb, d}, {8'h5A, 64'hCAFE_F00D_0BAD_BEEF});
        check(act_cnt == a0, "R7 no row reopen on page hit", 72'(act_cnt), 72'(a0));
    endtask

    task automatic t_byte_enable();
        logic [63:0] d; logic [7:0] cb;
        host_req(1'b1, 11'd2, 11'd5, 64'hFFEE_DDCC_BBAA_9988, 8'hFF, 8'hFF);
        host_req(1'b1, 11'd2, 11'd5, 64'h0102_0304_0506_0708, 8'h00, 8'h0F);
        wait_open();
        host_read(11'd2, 11'd5, d, cb);
        check({cb, d} == {8'hF0, 64'hFFEE_DDCC_0506_0708}, "R4 partial lane write", {cb, d}, {8'hF0, 64'hFFEE_DDCC_0506_0708});
        host_req(1'b1, 11'd2, 11'd5, 64'h0, 8'h00, 8'h00);
        wait_open();
        host_read(11'd2, 11'd5, d, cb);
        check({cb, d} == {8'hF0, 64'hFFEE_DDCC_0506_0708}, "R4 zero enables leave word", {cb, d}, {8'hF0, 64'hFFEE_DDCC_0506_0708});
    endtask

    task automatic t_row_miss();
        int a0; logic [63:0] d; logic [7:0] cb;
        a0 = act_cnt;
        host_req(1'b1, 11'd7, 11'd1, 64'h7777_0000_7777_0000, 8'h77, 8'hFF);
        wait_open();
        check(act_cnt == a0 + 1, "R8 miss opens new row", 72'(act_cnt), 72'(a0 + 1));
        check(pre_viol == 0, "R8 precharge width", 72'(pre_viol), 72'd0);
        host_read(11'd1, 11'd2, d, cb);
        check({cb, d} == {8'hA1, 64'h1111_2222_3333_4444}, "R2 row address kept apart", {cb, d}, {8'hA1, 64'h1111_2222_3333_4444});
    endtask

    task automatic t_edo();
        logic [63:0] d; logic [7:0] cb;
        edo_en = 1'b1;
        host_read(11'd7, 11'd1, d, cb);
        check({cb, d} == {8'h77, 64'h7777_0000_7777_0000}, "R6 EDO capture after CAS rise", {cb, d}, {8'h77, 64'h7777_0000_7777_0000});
        host_read(11'd1, 11'd3, d, cb);
        check({cb, d} == {8'h3C, 64'h5555_6666_7777_8888}, "R6 EDO read after miss", {cb, d}, {8'h3C, 64'h5555_6666_7777_8888});
        edo_en = 1'b0;
    endtask

    task automatic t_refresh();
        int r0;
        r0 = ref_cnt;
        repeat (4200) @(negedge clk);
        check(ref_cnt > r0, "R9 periodic refresh issued", 72'(ref_cnt), 72'(r0 + 1));
        check(cbr_starts == ref_cnt && pre_viol == 0, "R9 refresh order and precharge", 72'(cbr_starts), 72'(ref_cnt));
        check(dram_ras_n && dram_cas_n == 8'hFF, "R9 page closed after refresh", {63'd0, dram_ras_n, dram_cas_n}, {63'd1, 8'hFF});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_fpm_rw();
        t_page_hit();
        t_byte_enable();
        t_row_miss();
        t_edo();
        check(rsp_cnt == 8, "R10 one response per read", 72'(rsp_cnt), 72'd8);
        t_refresh();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule